// File: doc/BRIEF.md
# Flash Erase Command Interface

This block models the device side of a NOR flash command interface in synthesizable form. The host issues bus write cycles carrying an address and a data byte. A two-write sequence, made of a setup byte and then a confirm byte, starts a block erase. The block keeps track of whether reads should return array contents or the status register. It imitates the busy time of an erase with a cycle counter. It also keeps a small erased flag for each block, so that a read in array mode shows the result of an erase.

Erase attempts can fail in three ways: the target block is locked, the programming supply is reported out of range, or the sequence is malformed. Each failure sets error bits in the status register. These bits are sticky and stay set until the host writes the clear command, so software can erase several blocks and then inspect the status once. Each block is protected by one bit of a lock mask input. The supply state comes from a single input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array mode, the read data register is 0000h, every block is un-erased (array reads return 0000h), and the status register reads 80h.
- R2: A read captures its data on the clock edge where rd_en is sampled. In array mode it returns FFFFh for an erased block and 0000h for any other block, with the block taken from the upper BLK_W address bits. In status mode it returns {8'h00, status}.
- R3: A write of 20h followed by a write of D0h to an unlocked block, with vpp_ok high, starts an erase that stays busy for exactly BUSY_CYC cycles. Status bit 7 reads 0 while busy and 1 when idle. When the busy time ends, that block's erased flag is set.
- R4: A confirm to a block whose lock_mask bit is 1 sets status bits 1 and 5, starts no busy period and leaves the block un-erased.
- R5: A confirm with vpp_ok low sets status bits 3 and 5 and erases nothing.
- R6: After 20h, a second write of any value other than D0h sets status bits 4 and 5, erases nothing, and leaves the block in status mode.
- R7: Error bits 1, 3, 4 and 5 stay set through later erases. A write of 50h clears all four of them.
- R8: A write of FFh selects array mode. A write of 70h selects status mode. After a confirm, or after an error on the second write, reads return status until FFh is written.
- R9: Every write made during the busy period is ignored, including FFh and 50h.
- R10: Outside erase setup, a write of any other value changes neither the mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; upper BLK_W bits select the block |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| vpp_ok | input | 1 | Programming supply in range |
| lock_mask | input | NBLK | One lock bit per block, 1 = locked |

## Verification
Every block is erased, first with the supply good and then with it bad, while a fixed lock mask locks some of the blocks. This separates the clean path, the locked path, the supply path and the combined failure, and the status byte and array reads are checked against a model held in the bench. Several wrong second bytes, including 20h, FFh and 50h, show that only D0h confirms. Status is sampled on the last busy cycle and on the first idle cycle, which pins down the length of the erase. Writes made during busy, and sticky errors carried across a clean erase, confirm R7 and R9.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_SETUP  = 2'd2
  } mode_t;

  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  localparam int SR_LOCK  = 1;
  localparam int SR_VPP   = 3;
  localparam int SR_SEQ   = 4;
  localparam int SR_ERASE = 5;
  localparam int SR_READY = 7;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              vpp_ok,
  input  logic [NBLK-1:0]   lock_mask,
  output mode_t             mode,
  output logic [6:0]        err,
  output logic              start,
  output logic [BLK_W-1:0]  start_blk
);
  logic accept;
  logic confirm;
  logic blk_locked;

  assign accept     = wr_en && !busy;
  assign start_blk  = wr_addr[ADDR_W-1 -: BLK_W];
  assign blk_locked = lock_mask[start_blk];
  assign confirm    = accept && (mode == MODE_SETUP) && (wr_data == CMD_CONFIRM);
  assign start      = confirm && !blk_locked && vpp_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_ARRAY;
      err  <= '0;
    end else if (accept) begin
      if (mode == MODE_SETUP) begin
        mode <= MODE_STATUS;
        if (wr_data == CMD_CONFIRM) begin
          if (blk_locked) begin
            err[SR_LOCK]  <= 1'b1;
            err[SR_ERASE] <= 1'b1;
          end
          if (!vpp_ok) begin
            err[SR_VPP]   <= 1'b1;
            err[SR_ERASE] <= 1'b1;
          end
        end else begin
          err[SR_SEQ]   <= 1'b1;
          err[SR_ERASE] <= 1'b1;
        end
      end else begin
        case (wr_data)
          CMD_SETUP:  mode <= MODE_SETUP;
          CMD_ARRAY:  mode <= MODE_ARRAY;
          CMD_STATUS: mode <= MODE_STATUS;
          CMD_CLEAR: begin
            err[SR_LOCK]  <= 1'b0;
            err[SR_VPP]   <= 1'b0;
            err[SR_SEQ]   <= 1'b0;
            err[SR_ERASE] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int BUSY_CYC = 16,
  parameter int BLK_W    = 4,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] start_blk,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] done_blk
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      done_blk <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(BUSY_CYC - 1);
      done_blk <= start_blk;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_blk_state.sv
module flash_blk_state #(
  parameter int BLK_W = 4,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_erased,
  output logic [NBLK-1:0]  erased
);
  assign rd_erased = erased[rd_blk];

  always_ff @(posedge clk) begin
    if (rst) erased <= '0;
    else if (set_en) erased[set_blk] <= 1'b1;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_W    = 4,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 16,
  localparam int NBLK    = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vpp_ok,
  input  logic [NBLK-1:0]   lock_mask
);
  mode_t            mode_w;
  logic [6:0]       err_w;
  logic             start_w;
  logic [BLK_W-1:0] start_blk_w;
  logic             busy_w;
  logic             done_w;
  logic [BLK_W-1:0] done_blk_w;
  logic             rd_erased_w;
  logic [NBLK-1:0]  erased_w;
  logic [7:0]       status_w;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_w), .vpp_ok(vpp_ok), .lock_mask(lock_mask),
    .mode(mode_w), .err(err_w), .start(start_w), .start_blk(start_blk_w)
  );

  flash_erase_timer #(.BUSY_CYC(BUSY_CYC), .BLK_W(BLK_W)) u_timer (
    .clk(clk), .rst(rst), .start(start_w), .start_blk(start_blk_w),
    .busy(busy_w), .done(done_w), .done_blk(done_blk_w)
  );

  flash_blk_state #(.BLK_W(BLK_W)) u_blk (
    .clk(clk), .rst(rst), .set_en(done_w), .set_blk(done_blk_w),
    .rd_blk(rd_addr[ADDR_W-1 -: BLK_W]), .rd_erased(rd_erased_w),
    .erased(erased_w)
  );

  assign status_w = {~busy_w, err_w};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (mode_w == MODE_ARRAY) rd_data <= rd_erased_w ? '1 : '0;
      else                      rd_data <= DATA_W'(status_w);
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 16,
  localparam int NBLK  = 1 << BLK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [NBLK-1:0]   lock_mask,
  input logic              busy,
  input mode_t             mode,
  input logic [6:0]        err,
  input logic [NBLK-1:0]   erased
);
  logic take;
  assign take = wr_en && !busy;

  // R3
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && busy |=> rd_data[SR_READY] == 1'b0);

  // R3
  start_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(take && mode == MODE_SETUP && wr_data == CMD_CONFIRM));

  // R3
  erased_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(erased));

  // R4
  locked_no_erase_chk: assert property (@(posedge clk) disable iff (rst)
    take && mode == MODE_SETUP && wr_data == CMD_CONFIRM
      && lock_mask[wr_addr[ADDR_W-1 -: BLK_W]] |=> !busy && err[SR_LOCK]);

  // R7
  sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
    err[SR_ERASE] && !(take && mode != MODE_SETUP && wr_data == CMD_CLEAR)
      |=> err[SR_ERASE]);

  // R8
  array_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    take && mode != MODE_SETUP && wr_data == CMD_ARRAY |=> mode == MODE_ARRAY);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(err) && $stable(mode));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .lock_mask(lock_mask),
  .busy(busy_w), .mode(mode_w), .err(err_w), .erased(erased_w)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int BLK_W  = 3;
  localparam int NBLK   = 1 << BLK_W;
  localparam int DATA_W = 16;
  localparam int BUSY   = 5;
  localparam logic [NBLK-1:0] LOCKS = 8'b0110_1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic vpp_ok = 1'b1;
  logic [NBLK-1:0] lock_mask = LOCKS;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [NBLK-1:0] model_erased;
  logic [7:0] exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY))
    i_flash_cmd_ctrl (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .vpp_ok(vpp_ok), .lock_mask(lock_mask));

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] baddr(input int b, input int off);
    return ADDR_W'((b << (ADDR_W - BLK_W)) + off);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_erased = '0;
    exp_err = 8'h00;
  endtask

  task automatic check_block(input string req, input int b);
    logic [DATA_W-1:0] v;
    wr(0, 8'hFF);
    rd(baddr(b, b), v);
    chk(req, v, model_erased[b] ? 16'hFFFF : 16'h0000);
  endtask

  // Issue setup and confirm, then check status timing according to the model.
  task automatic erase(input string req, input int b);
    logic [DATA_W-1:0] v;
    bit go;
    go = !LOCKS[b] && vpp_ok;
    if (LOCKS[b]) exp_err = exp_err | 8'h22;
    if (!vpp_ok)  exp_err = exp_err | 8'h28;
    wr(baddr(b, 0), 8'h20);
    wr(baddr(b, 3), 8'hD0);
    if (go) begin
      repeat (BUSY - 1) @(negedge clk);
      rd(0, v);
      chk(req, v, {8'h00, exp_err});
      rd(0, v);
      chk(req, v, {8'h00, exp_err | 8'h80});
      model_erased[b] = 1'b1;
    end else begin
      rd(0, v);
      chk(req, v, {8'h00, exp_err | 8'h80});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic [7:0] seqs [4] = '{8'h00, 8'h20, 8'hFF, 8'h50};
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0000);
    rd(baddr(0, 0), v);
    chk("R1 array", v, 16'h0000);
    wr(0, 8'h70);
    rd(0, v);
    chk("R1 status", v, 16'h0080);

    // R10 ignored writes in status and array mode
    wr(0, 8'h00);
    rd(0, v);
    chk("R10 status kept", v, 16'h0080);
    wr(0, 8'hFF);
    wr(0, 8'h3C);
    rd(0, v);
    chk("R10 array kept", v, 16'h0000);

    // Sweep: all blocks, supply good then bad (R2 R3 R4 R5)
    for (int pass = 0; pass < 2; pass++) begin
      do_reset();
      vpp_ok = (pass == 0);
      for (int b = 0; b < NBLK; b++) begin
        wr(0, 8'h50);
        exp_err = 8'h00;
        if (LOCKS[b]) erase("R4 locked", b);
        else if (!vpp_ok) erase("R5 supply", b);
        else erase("R3 erase", b);
        // R8 reads stay on status until FFh
        rd(baddr(b, 1), v);
        chk("R8 status after confirm", v, {8'h00, exp_err | 8'h80});
        check_block("R2 array", b);
      end
      for (int b = 0; b < NBLK; b++) check_block("R2 sweep", b);
    end
    vpp_ok = 1'b1;

    // R6 wrong second byte
    do_reset();
    for (int i = 0; i < 4; i++) begin
      wr(0, 8'h50);
      wr(baddr(1, 0), 8'h20);
      wr(baddr(1, 0), seqs[i]);
      rd(0, v);
      chk("R6 seq error", v, 16'h00B0);
      check_block("R6 no erase", 1);
    end

    // R7 sticky through a clean erase, then cleared
    wr(0, 8'h50);
    exp_err = 8'h00;
    erase("R7 locked", 0);
    erase("R7 sticky", 1);
    chk("R7 model", {8'h00, exp_err}, 16'h0022);
    wr(0, 8'h50);
    rd(0, v);
    chk("R7 cleared", v, 16'h0080);

    // R9 writes during busy ignored
    wr(0, 8'h20);
    wr(0, 8'h11);
    exp_err = 8'h30;
    wr(baddr(2, 0), 8'h20);
    wr(baddr(2, 0), 8'hD0);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    repeat (BUSY) @(negedge clk);
    rd(0, v);
    chk("R9 busy ignored", v, 16'h00B0);
    model_erased[2] = 1'b1;
    check_block("R9 erased", 2);

    // R8 status command
    wr(0, 8'h70);
    rd(0, v);
    chk("R8 status cmd", v, 16'h00B0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule